// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves one branch per clock for a machine with 40-bit (5-byte) instruction words and a 64-bit program counter. For each issued operation it is handed a branch class, the value of one general register, a 6-bit bit index, the address of the branch instruction and the raw displacement/address field. From these it decides whether the branch is taken. It produces the address that fetch should continue from and, for subroutine branches and calls, raises a request to write a return address together with the value to save. The write itself is left to the register file.

Conditional branches come in two forms. One form picks a single bit out of a compare-result vector held in a general register. The other form tests the register itself for zero, nonzero, negative or strictly positive. Conditional branches use a short relative displacement. Unconditional relative branches and subroutine branches use a wider relative displacement. Absolute jumps and calls use either a short or a long address field, and the long field is cut down to the program-counter width. Results appear on registered outputs one cycle after the operation is presented.

Top module: `br_resolve`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, every output is zero.
- R2: Outputs are valid exactly one cycle after the inputs. `o_valid` equals `i_valid` from the previous edge. When `o_valid` is 0, both `o_taken` and `o_link_we` are 0.
- R3: Class 0 (bit test) is taken exactly when bit `i_idx` of `i_reg` is 1. Index 0 is the least significant bit and index 63 the most significant.
- R4: Classes 1..4 test `i_reg` as a signed 64-bit value. Class 1 is taken if it is zero, class 2 if it is nonzero, class 3 if it is below zero and class 4 if it is above zero. Zero is not above zero.
- R5: A taken conditional branch (classes 0..4) targets `i_pc` plus `i_field[19:0]` sign-extended, modulo 2^64. Field bits 69:20 have no effect.
- R6: A conditional branch that is not taken, and any operation with an unassigned class (11..15), gives `o_taken`=0 and `o_target` = `i_pc`+5 modulo 2^64.
- R7: Class 5 (relative branch) and class 6 (relative subroutine branch) are always taken. Their target is `i_pc` plus `i_field[29:0]` sign-extended, modulo 2^64.
- R8: Classes 7 (jump) and 9 (call) are always taken, with target `i_field[29:0]` zero-extended. Classes 8 (jump) and 10 (call) are always taken, with target `i_field[63:0]`. Field bits 69:64 have no effect.
- R9: Classes 6, 9 and 10 set `o_link_we`=1 with `o_link_addr` = `i_pc`+5. Every other class gives `o_link_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | A branch operation is presented |
| i_class | input | 4 | Branch class code (see R3..R9) |
| i_reg | input | 64 | Source register value (compare vector or tested value) |
| i_idx | input | 6 | Bit index for the compare-vector test |
| i_pc | input | 64 | Address of the branch instruction |
| i_field | input | 70 | Raw displacement or absolute address field |
| o_valid | output | 1 | Result valid |
| o_taken | output | 1 | Branch taken |
| o_target | output | 64 | Next fetch address |
| o_link_we | output | 1 | Return-address write requested |
| o_link_addr | output | 64 | Return address to save |

## Verification
The hardest cases to reach with random data are the ones that need a register value or a field with an exact shape. Examples are a register exactly zero or exactly the most negative value for the sign tests, a selected vector bit at index 0 or 63, and fields whose ignored upper bits are set while the used bits are small. A program counter close enough to either end of the address space makes the sum wrap. Random operations are therefore biased toward zero, all-ones and single-bit register values and toward extreme program counters. They are preceded by directed operations that set each of these shapes on purpose, including an idle cycle that carries a call class.

// File: rtl/br_resolve_pkg.sv
`timescale 1ns/1ps
package br_resolve_pkg;

   typedef enum logic [3:0] {
      BC_VEC_BIT = 4'd0,
      BC_ZERO    = 4'd1,
      BC_NONZERO = 4'd2,
      BC_NEG     = 4'd3,
      BC_POS     = 4'd4,
      BC_REL     = 4'd5,
      BC_REL_SUB = 4'd6,
      BC_ABS_S   = 4'd7,
      BC_ABS_L   = 4'd8,
      BC_CALL_S  = 4'd9,
      BC_CALL_L  = 4'd10
   } br_class_e;

   function automatic logic class_is_cond(logic [3:0] c);
      return c <= 4'd4;
   endfunction

   function automatic logic class_is_uncond(logic [3:0] c);
      return (c >= 4'd5) && (c <= 4'd10);
   endfunction

   function automatic logic class_saves_link(logic [3:0] c);
      return (c == BC_REL_SUB) || (c == BC_CALL_S) || (c == BC_CALL_L);
   endfunction

endpackage

// File: rtl/br_resolve_cond.sv
`timescale 1ns/1ps
module br_resolve_cond
   import br_resolve_pkg::*;
#(
   parameter int REG_W = 64,
   localparam int IDX_W = $clog2(REG_W)
) (
   input  logic [3:0]       cls,
   input  logic [REG_W-1:0] src,
   input  logic [IDX_W-1:0] idx,
   output logic             cond_true
);

   logic bit_hit;
   logic is_zero;
   logic is_neg;
   logic is_pos;

   assign bit_hit = src[idx];
   assign is_zero = (src == '0);
   assign is_neg  = src[REG_W-1];
   assign is_pos  = !is_zero && !is_neg;

   always_comb begin
      unique case (br_class_e'(cls))
         BC_VEC_BIT: cond_true = bit_hit;
         BC_ZERO:    cond_true = is_zero;
         BC_NONZERO: cond_true = !is_zero;
         BC_NEG:     cond_true = is_neg;
         BC_POS:     cond_true = is_pos;
         default:    cond_true = 1'b0;
      endcase
   end

endmodule

// File: rtl/br_resolve_tgt.sv
`timescale 1ns/1ps
module br_resolve_tgt
   import br_resolve_pkg::*;
#(
   parameter int PC_W        = 64,
   parameter int COND_DISP_W = 20,
   parameter int UNC_DISP_W  = 30,
   parameter int ABS_S_W     = 30,
   parameter int ABS_L_W     = 70,
   parameter int INSN_BYTES  = 5
) (
   input  logic [3:0]         cls,
   input  logic               cond_true,
   input  logic [PC_W-1:0]    pc,
   input  logic [ABS_L_W-1:0] field,
   output logic               taken,
   output logic [PC_W-1:0]    target,
   output logic               link_we,
   output logic [PC_W-1:0]    link_addr
);

   localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

   logic [PC_W-1:0] fall_pc;
   logic [PC_W-1:0] cond_off;
   logic [PC_W-1:0] unc_off;
   logic [PC_W-1:0] abs_short;
   logic [PC_W-1:0] abs_long;
   logic [PC_W-1:0] rel_cond;
   logic [PC_W-1:0] rel_unc;

   assign fall_pc  = pc + STEP;
   assign cond_off = {{(PC_W-COND_DISP_W){field[COND_DISP_W-1]}}, field[COND_DISP_W-1:0]};
   assign unc_off  = {{(PC_W-UNC_DISP_W){field[UNC_DISP_W-1]}}, field[UNC_DISP_W-1:0]};
   assign rel_cond = pc + cond_off;
   assign rel_unc  = pc + unc_off;
   assign abs_short = {{(PC_W-ABS_S_W){1'b0}}, field[ABS_S_W-1:0]};

   generate
      if (ABS_L_W > PC_W) begin : g_long_trunc
         logic unused_field_hi;
         assign unused_field_hi = ^field[ABS_L_W-1:PC_W];
         assign abs_long = field[PC_W-1:0];
      end else if (ABS_L_W == PC_W) begin : g_long_exact
         assign abs_long = field;
      end else begin : g_long_zext
         assign abs_long = {{(PC_W-ABS_L_W){1'b0}}, field};
      end
   endgenerate

   always_comb begin
      taken  = 1'b0;
      target = fall_pc;
      unique case (br_class_e'(cls))
         BC_VEC_BIT, BC_ZERO, BC_NONZERO, BC_NEG, BC_POS: begin
            taken  = cond_true;
            target = cond_true ? rel_cond : fall_pc;
         end
         BC_REL, BC_REL_SUB: begin
            taken  = 1'b1;
            target = rel_unc;
         end
         BC_ABS_S, BC_CALL_S: begin
            taken  = 1'b1;
            target = abs_short;
         end
         BC_ABS_L, BC_CALL_L: begin
            taken  = 1'b1;
            target = abs_long;
         end
         default: begin
            taken  = 1'b0;
            target = fall_pc;
         end
      endcase
   end

   assign link_we   = class_saves_link(cls);
   assign link_addr = fall_pc;

endmodule

// File: rtl/br_resolve_stage.sv
`timescale 1ns/1ps
module br_resolve_stage #(
   parameter int PC_W    = 64,
   parameter bit OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            d_valid,
   input  logic            d_taken,
   input  logic [PC_W-1:0] d_target,
   input  logic            d_link_we,
   input  logic [PC_W-1:0] d_link_addr,
   output logic            q_valid,
   output logic            q_taken,
   output logic [PC_W-1:0] q_target,
   output logic            q_link_we,
   output logic [PC_W-1:0] q_link_addr
);

   logic g_taken;
   logic g_link;

   assign g_taken = d_valid && d_taken;
   assign g_link  = d_valid && d_link_we;

   generate
      if (OUT_REG) begin : g_flop
         always_ff @(posedge clk) begin
            if (rst) begin
               q_valid     <= 1'b0;
               q_taken     <= 1'b0;
               q_target    <= '0;
               q_link_we   <= 1'b0;
               q_link_addr <= '0;
            end else begin
               q_valid     <= d_valid;
               q_taken     <= g_taken;
               q_target    <= d_target;
               q_link_we   <= g_link;
               q_link_addr <= d_link_addr;
            end
         end
      end else begin : g_pass
         logic unused_clk;
         assign unused_clk  = clk ^ rst;
         assign q_valid     = d_valid;
         assign q_taken     = g_taken;
         assign q_target    = d_target;
         assign q_link_we   = g_link;
         assign q_link_addr = d_link_addr;
      end
   endgenerate

endmodule

// File: rtl/br_resolve.sv
`timescale 1ns/1ps
module br_resolve
   import br_resolve_pkg::*;
#(
   parameter int PC_W        = 64,
   parameter int REG_W       = 64,
   parameter int COND_DISP_W = 20,
   parameter int UNC_DISP_W  = 30,
   parameter int ABS_S_W     = 30,
   parameter int ABS_L_W     = 70,
   parameter int INSN_BYTES  = 5,
   parameter bit OUT_REG     = 1'b1,
   localparam int IDX_W      = $clog2(REG_W)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               i_valid,
   input  logic [3:0]         i_class,
   input  logic [REG_W-1:0]   i_reg,
   input  logic [IDX_W-1:0]   i_idx,
   input  logic [PC_W-1:0]    i_pc,
   input  logic [ABS_L_W-1:0] i_field,
   output logic               o_valid,
   output logic               o_taken,
   output logic [PC_W-1:0]    o_target,
   output logic               o_link_we,
   output logic [PC_W-1:0]    o_link_addr
);

   localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

   generate
      if ((1 << IDX_W) != REG_W) begin : g_chk_reg
         $error("REG_W must be a power of two");
      end
      if (COND_DISP_W >= PC_W || UNC_DISP_W >= PC_W || ABS_S_W >= PC_W) begin : g_chk_disp
         $error("short fields must be narrower than the program counter");
      end
      if (ABS_L_W < ABS_S_W || ABS_L_W < UNC_DISP_W || ABS_L_W < COND_DISP_W) begin : g_chk_field
         $error("ABS_L_W sets the field port and must be the widest field");
      end
      if (INSN_BYTES < 1) begin : g_chk_len
         $error("INSN_BYTES must be positive");
      end
   endgenerate

   logic            cond_true;
   logic            c_taken;
   logic [PC_W-1:0] c_target;
   logic            c_link_we;
   logic [PC_W-1:0] c_link_addr;

   br_resolve_cond #(.REG_W(REG_W)) u_cond (
      .cls       (i_class),
      .src       (i_reg),
      .idx       (i_idx),
      .cond_true (cond_true)
   );

   br_resolve_tgt #(
      .PC_W        (PC_W),
      .COND_DISP_W (COND_DISP_W),
      .UNC_DISP_W  (UNC_DISP_W),
      .ABS_S_W     (ABS_S_W),
      .ABS_L_W     (ABS_L_W),
      .INSN_BYTES  (INSN_BYTES)
   ) u_tgt (
      .cls       (i_class),
      .cond_true (cond_true),
      .pc        (i_pc),
      .field     (i_field),
      .taken     (c_taken),
      .target    (c_target),
      .link_we   (c_link_we),
      .link_addr (c_link_addr)
   );

   br_resolve_stage #(.PC_W(PC_W), .OUT_REG(OUT_REG)) u_stage (
      .clk         (clk),
      .rst         (rst),
      .d_valid     (i_valid),
      .d_taken     (c_taken),
      .d_target    (c_target),
      .d_link_we   (c_link_we),
      .d_link_addr (c_link_addr),
      .q_valid     (o_valid),
      .q_taken     (o_taken),
      .q_target    (o_target),
      .q_link_we   (o_link_we),
      .q_link_addr (o_link_addr)
   );

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !o_valid |-> (!o_taken && !o_link_we));

   a_r9_link_needs_taken: assert property (@(posedge clk) disable iff (rst)
      o_link_we |-> o_taken);

   generate
      if (OUT_REG) begin : g_seq_chk
         a_r6_fallthrough: assert property (@(posedge clk) disable iff (rst)
            (o_valid && !o_taken) |-> (o_target == $past(i_pc) + STEP));

         a_r9_link_value: assert property (@(posedge clk) disable iff (rst)
            o_link_we |-> (o_link_addr == $past(i_pc) + STEP));

         a_r7_uncond_taken: assert property (@(posedge clk) disable iff (rst)
            (o_valid && class_is_uncond($past(i_class))) |-> o_taken);

         a_r3_vector_bit: assert property (@(posedge clk) disable iff (rst)
            (o_valid && $past(i_class) == 4'd0) |-> (o_taken == $past(i_reg[i_idx])));

         a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
            (o_valid && $past(i_class) >= 4'd11) |-> (!o_taken && !o_link_we));
      end
   endgenerate

endmodule

// File: tb/br_resolve_tb.sv
`timescale 1ns/1ps
module br_resolve_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        i_valid = 1'b0;
   logic [3:0]  i_class = '0;
   logic [63:0] i_reg = '0;
   logic [5:0]  i_idx = '0;
   logic [63:0] i_pc = '0;
   logic [69:0] i_field = '0;
   logic        o_valid, o_taken, o_link_we;
   logic [63:0] o_target, o_link_addr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   br_resolve u_dut (
      .clk(clk), .rst(rst), .i_valid(i_valid), .i_class(i_class), .i_reg(i_reg),
      .i_idx(i_idx), .i_pc(i_pc), .i_field(i_field), .o_valid(o_valid),
      .o_taken(o_taken), .o_target(o_target), .o_link_we(o_link_we),
      .o_link_addr(o_link_addr)
   );

   function automatic logic [63:0] sx(logic [63:0] v, int bits);
      logic [63:0] m;
      m = (64'd1 << bits) - 64'd1;
      v = v & m;
      if (v >= (64'd1 << (bits - 1))) return v - (64'd1 << bits);
      return v;
   endfunction

   function automatic logic exp_taken(logic [3:0] c, logic [63:0] r, logic [5:0] ix);
      case (c)
         4'd0: return (r >> ix) & 64'd1 ? 1'b1 : 1'b0;
         4'd1: return r == 64'd0;
         4'd2: return r != 64'd0;
         4'd3: return $signed(r) < 0;
         4'd4: return $signed(r) > 0;
         4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [63:0] exp_target(logic [3:0] c, logic tk, logic [63:0] pc,
                                              logic [69:0] f);
      if (!tk) return pc + 64'd5;
      case (c)
         4'd5, 4'd6: return pc + sx(f[63:0], 30);
         4'd7, 4'd9: return f[63:0] & 64'h3FFF_FFFF;
         4'd8, 4'd10: return f[63:0];
         default: return pc + sx(f[63:0], 20);
      endcase
   endfunction

   task automatic chk(logic [63:0] act, logic [63:0] exp, string req, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run(logic v, logic [3:0] c, logic [63:0] r, logic [5:0] ix,
                      logic [63:0] pc, logic [69:0] f);
      logic        tk;
      logic        lk;
      string       rq;
      @(negedge clk);
      i_valid = v; i_class = c; i_reg = r; i_idx = ix; i_pc = pc; i_field = f;
      tk = v && exp_taken(c, r, ix);
      lk = v && (c == 4'd6 || c == 4'd9 || c == 4'd10);
      if (c == 4'd0) rq = "R3";
      else if (c <= 4'd4) rq = tk ? "R5" : "R4";
      else if (c == 4'd5 || c == 4'd6) rq = "R7";
      else if (c <= 4'd10) rq = "R8";
      else rq = "R6";
      @(posedge clk);
      #2;
      chk(64'(o_valid), 64'(v), "R2", "valid");
      chk(64'(o_taken), 64'(tk), (c <= 4'd4) ? ((c == 4'd0) ? "R3" : "R4") : rq, "taken");
      if (v) chk(o_target, exp_target(c, tk, pc, f), tk ? rq : "R6", "target");
      chk(64'(o_link_we), 64'(lk), "R9", "link_we");
      if (lk) chk(o_link_addr, pc + 64'd5, "R9", "link_addr");
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      #4_000_000;
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20251102));
      repeat (3) @(posedge clk);
      #2;
      // R1: outputs cleared during reset
      chk(64'(o_valid), 64'd0, "R1", "valid in reset");
      chk(64'(o_taken), 64'd0, "R1", "taken in reset");
      chk(o_target, 64'd0, "R1", "target in reset");
      chk(64'(o_link_we), 64'd0, "R1", "link_we in reset");
      chk(o_link_addr, 64'd0, "R1", "link_addr in reset");
      i_valid = 1'b1; i_class = 4'd6;
      @(negedge clk);
      rst = 1'b0;
      i_valid = 1'b0;

      // R3 bit-vector edges
      run(1, 4'd0, 64'h8000_0000_0000_0000, 6'd63, 64'h1000, 70'h0_0010);
      run(1, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 6'd63, 64'h1000, 70'h0_0010);
      run(1, 4'd0, 64'h0000_0000_0000_0001, 6'd0, 64'h1000, 70'hF_FFF0);
      run(1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFE, 6'd0, 64'h1000, 70'hF_FFF0);
      // R4 sign and zero tests
      run(1, 4'd1, 64'd0, 6'd0, 64'h2000, 70'h0_0100);
      run(1, 4'd2, 64'd0, 6'd0, 64'h2000, 70'h0_0100);
      run(1, 4'd3, 64'h8000_0000_0000_0000, 6'd0, 64'h2000, 70'h0_0100);
      run(1, 4'd4, 64'd0, 6'd0, 64'h2000, 70'h0_0100);
      run(1, 4'd4, 64'h8000_0000_0000_0000, 6'd0, 64'h2000, 70'h0_0100);
      run(1, 4'd4, 64'd1, 6'd0, 64'h2000, 70'h0_0100);
      // R5: negative displacement wraps below zero; upper field bits ignored
      run(1, 4'd1, 64'd0, 6'd0, 64'h4, {50'h3_FFFF_FFFF_FFFF, 20'h8_0000});
      // R6: wrap of fall-through, reserved codes
      run(1, 4'd2, 64'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFE, 70'h0_0100);
      run(1, 4'd11, 64'd5, 6'd0, 64'h3000, 70'h0_1234);
      run(1, 4'd15, 64'hFFFF, 6'd3, 64'h3000, 70'h0_1234);
      // R7 relative unconditional, negative and positive
      run(1, 4'd5, 64'd0, 6'd0, 64'h10_0000, 70'h2000_0000);
      run(1, 4'd6, 64'd0, 6'd0, 64'h10_0000, {40'hFF_FFFF_FFFF, 30'h1FFF_FFFF});
      // R8 absolute short with ignored upper bits, long truncated
      run(1, 4'd7, 64'd0, 6'd0, 64'h5000, {40'hFF_FFFF_FFFF, 30'h3FFF_FFFC});
      run(1, 4'd9, 64'd0, 6'd0, 64'h5000, 70'h0_1000);
      run(1, 4'd8, 64'd0, 6'd0, 64'h5000, {6'h3F, 64'hDEAD_BEEF_0000_1234});
      run(1, 4'd10, 64'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFD, {6'h15, 64'h8000_0000_0000_0008});
      // R2: idle cycle carrying a call class
      run(0, 4'd10, 64'd0, 6'd0, 64'h6000, 70'h0_0040);
      run(0, 4'd5, 64'd0, 6'd0, 64'h6000, 70'h0_0040);

      for (int n = 0; n < 400; n++) begin
         logic [63:0] r;
         logic [63:0] pc;
         logic [69:0] f;
         int sel;
         sel = $urandom % 5;
         case (sel)
            0: r = 64'd0;
            1: r = 64'hFFFF_FFFF_FFFF_FFFF;
            2: r = 64'd1 << ($urandom % 64);
            default: r = rnd64();
         endcase
         sel = $urandom % 4;
         case (sel)
            0: pc = 64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom % 16);
            1: pc = 64'($urandom % 16);
            default: pc = rnd64();
         endcase
         f = {6'($urandom), rnd64()};
         run(($urandom % 8) != 0, 4'($urandom), r, 6'($urandom), pc, f);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule